// File: doc/BRIEF.md
# UART Raw Interrupt Status Logic

This block keeps the raw interrupt flags of a UART. Single-cycle event pulses from the receiver, the transmitter and the modem-control path set sticky flags. The receive and transmit flags also follow the fill levels of their FIFOs. Each of those two flags sets when its FIFO level moves into the region defined by a programmed trigger fraction. It clears by itself when FIFO traffic moves the level back out of that region.

When the FIFOs are disabled, each holding register behaves as a one-entry buffer:
- The receive flag sets when a byte arrives and clears when that byte is read.
- The transmit flag sets when the buffer empties and clears on the next byte written.

In end-of-transmission mode the transmit flag ignores the FIFO level. It then sets only when the serializer reports that the last bit has gone out.

Software reads the status word and clears bits by writing ones to a clear port. A mask register gates the flags onto one combined interrupt line.

Top module: `uart_irq_status`

## Requirements
- R1: After reset all status bits, the mask register and `irq` are 0.
- R2: Status layout: bit 7 framing error, bit 6 receive time-out, bit 5 transmit, bit 4 receive, bit 1 clear-to-send. Bits 3, 2 and 0 always read 0.
- R3: A one-cycle pulse on `evt_frame_err`, `evt_rx_timeout` or `evt_cts_change` sets its status bit from the next clock edge. The bit then holds until it is cleared.
- R4: A cycle with `clr_we` high clears every status bit whose `clr_data` bit is 1. Bits written as 0 keep their value.
- R5: When a set condition and a clear act on the same bit in the same cycle, the bit ends up set.
- R6: With `fifo_en`=1, the receive flag sets when `rx_level` goes from below the threshold T to at least T, compared with the previous cycle. Staying at or above T does not set it again. `rx_trig_sel` codes map to T as follows: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12, and 4 to 7 give 14, for a 16-entry FIFO.
- R7: With `fifo_en`=1, the receive flag clears when `rx_level` goes from at least T to below T.
- R8: With `fifo_en`=0, the receive flag sets when `rx_level` goes from 0 to a nonzero value. It clears on an `rx_byte_read` pulse, and a level change does not clear it.
- R9: With `fifo_en`=1 and `eot_mode`=0, the transmit flag sets when `tx_level` goes from above T to at most T. It clears when `tx_level` goes from at most T to above T. T comes from `tx_trig_sel` with the same encoding as R6.
- R10: With `fifo_en`=0 and `eot_mode`=0, the transmit flag sets when `tx_level` goes from nonzero to 0. It clears on a `tx_byte_write` pulse.
- R11: With `eot_mode`=1, the transmit flag sets only on an `evt_ser_idle` pulse. A `tx_level` crossing does not set it.
- R12: `irq` is the OR of the status bits ANDed with the mask register. The mask loads from `mask_data` on a cycle with `mask_we`=1, and its reserved bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_frame_err | input | 1 | Framing error pulse |
| evt_rx_timeout | input | 1 | Receive time-out pulse |
| evt_cts_change | input | 1 | Clear-to-send change pulse |
| evt_ser_idle | input | 1 | Serializer finished last bit pulse |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_trig_sel | input | 3 | Receive trigger fraction code |
| tx_trig_sel | input | 3 | Transmit trigger fraction code |
| fifo_en | input | 1 | FIFO mode enable |
| eot_mode | input | 1 | End-of-transmission mode for the transmit flag |
| rx_byte_read | input | 1 | Byte read from receive holding register (FIFO off) |
| tx_byte_write | input | 1 | Byte written to transmit holding register (FIFO off) |
| clr_we | input | 1 | Clear-port write strobe |
| clr_data | input | 8 | Write-one-to-clear bit pattern |
| mask_we | input | 1 | Mask register write strobe |
| mask_data | input | 8 | New mask value |
| raw_status | output | 8 | Raw status word |
| irq | output | 1 | Combined masked interrupt |

## Verification
A stuck or lost flag shows on `raw_status` one clock edge after the event or clear that should have moved it. Each scenario therefore reads the word right after every stimulus edge.

A wrong previous-level register shows up in two ways. It can produce a spurious set while the level sits still inside the trigger region. It can also miss the set on the crossing edge itself. The level sweeps hold the level steady for extra cycles to expose both.

A wrong mask register or mask gating appears on `irq` in the cycle after the mask write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int STAT_W = 8;

  localparam int BIT_FRAME = 7;
  localparam int BIT_RXTO  = 6;
  localparam int BIT_TX    = 5;
  localparam int BIT_RX    = 4;
  localparam int BIT_CTS   = 1;

  localparam logic [STAT_W-1:0] VALID_BITS = 8'b1111_0010;

  typedef enum logic [2:0] {
    TRIG_EIGHTH   = 3'd0,
    TRIG_QUARTER  = 3'd1,
    TRIG_HALF     = 3'd2,
    TRIG_3QUARTER = 3'd3,
    TRIG_7EIGHTHS = 3'd4
  } trig_sel_e;

  // Threshold in entries for a fraction code; codes above 4 saturate to 7/8.
  function automatic int trig_level(input logic [2:0] sel, input int depth);
    case (sel)
      TRIG_EIGHTH:   trig_level = depth / 8;
      TRIG_QUARTER:  trig_level = depth / 4;
      TRIG_HALF:     trig_level = depth / 2;
      TRIG_3QUARTER: trig_level = (depth * 3) / 4;
      default:       trig_level = (depth * 7) / 8;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh #(
  parameter int DEPTH  = 16,
  parameter int LVL_W  = $clog2(DEPTH) + 1,
  parameter bit RISING = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [2:0]       trig_sel,
  input  logic             fifo_en,
  output logic             enter,
  output logic             leave
);
  import uart_irq_pkg::*;

  // Threshold used while the FIFO is off: one-entry buffer.
  localparam int NOFIFO_THR = RISING ? 1 : 0;

  logic [LVL_W-1:0] prev_q;
  logic [LVL_W-1:0] prev_d;
  logic [LVL_W-1:0] thr;
  logic             cur_in;
  logic             prev_in;

  always_comb begin
    if (fifo_en) begin
      thr = LVL_W'(trig_level(trig_sel, DEPTH));
    end else begin
      thr = LVL_W'(NOFIFO_THR);
    end
  end

  generate
    if (RISING) begin : g_fill
      always_comb begin
        cur_in  = (level  >= thr);
        prev_in = (prev_q >= thr);
      end
    end else begin : g_drain
      always_comb begin
        cur_in  = (level  <= thr);
        prev_in = (prev_q <= thr);
      end
    end
  endgenerate

  always_comb begin
    prev_d = level;
    enter  = cur_in & ~prev_in;
    leave  = ~cur_in & prev_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set | clr;
    q_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (q_en) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_frame_err,
  input  logic             evt_rx_timeout,
  input  logic             evt_cts_change,
  input  logic             evt_ser_idle,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [2:0]       rx_trig_sel,
  input  logic [2:0]       tx_trig_sel,
  input  logic             fifo_en,
  input  logic             eot_mode,
  input  logic             rx_byte_read,
  input  logic             tx_byte_write,
  input  logic             clr_we,
  input  logic [7:0]       clr_data,
  input  logic             mask_we,
  input  logic [7:0]       mask_data,
  output logic [7:0]       raw_status,
  output logic             irq
);
  import uart_irq_pkg::*;

  logic              rx_enter, rx_leave;
  logic              tx_enter, tx_leave;
  logic [STAT_W-1:0] set_v;
  logic [STAT_W-1:0] clr_v;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] mask_d;

  uart_irq_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W), .RISING(1'b1)) u_rx_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (rx_level),
    .trig_sel (rx_trig_sel),
    .fifo_en  (fifo_en),
    .enter    (rx_enter),
    .leave    (rx_leave)
  );

  uart_irq_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W), .RISING(1'b0)) u_tx_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (tx_level),
    .trig_sel (tx_trig_sel),
    .fifo_en  (fifo_en),
    .enter    (tx_enter),
    .leave    (tx_leave)
  );

  // Set and clear sources per bit.
  always_comb begin
    set_v = '0;
    set_v[BIT_FRAME] = evt_frame_err;
    set_v[BIT_RXTO]  = evt_rx_timeout;
    set_v[BIT_CTS]   = evt_cts_change;
    set_v[BIT_RX]    = rx_enter;
    set_v[BIT_TX]    = eot_mode ? evt_ser_idle : tx_enter;

    clr_v = clr_we ? clr_data : '0;
    clr_v[BIT_RX] = clr_v[BIT_RX] | (fifo_en ? rx_leave : rx_byte_read);
    clr_v[BIT_TX] = clr_v[BIT_TX] | (fifo_en ? tx_leave : tx_byte_write);
  end

  generate
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      if (VALID_BITS[b]) begin : g_flag
        uart_irq_flag u_flag (
          .clk   (clk),
          .rst_n (rst_n),
          .set   (set_v[b]),
          .clr   (clr_v[b]),
          .q     (raw_status[b])
        );
      end else begin : g_rsvd
        logic rsvd_unused;
        assign rsvd_unused   = set_v[b] ^ clr_v[b];
        assign raw_status[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    mask_d = mask_data & VALID_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  always_comb begin
    irq = |(raw_status & mask_q);
  end

endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_frame_err,
  input logic       evt_rx_timeout,
  input logic       evt_cts_change,
  input logic       evt_ser_idle,
  input logic       eot_mode,
  input logic       clr_we,
  input logic [7:0] clr_data,
  input logic [7:0] raw_status,
  input logic       irq
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[3] == 1'b0) && (raw_status[2] == 1'b0) && (raw_status[0] == 1'b0));

  // R3
  frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_err |=> raw_status[7]);

  // R3
  rxto_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_timeout |=> raw_status[6]);

  // R3
  cts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cts_change |=> raw_status[1]);

  // R4
  frame_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_data[7] && !evt_frame_err) |=> !raw_status[7]);

  // R4
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_frame_err && !(clr_we && clr_data[7])) |=> $stable(raw_status[7]));

  // R11
  eot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_mode && evt_ser_idle) |=> raw_status[5]);

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_status != 8'h00));

endmodule

bind uart_irq_status uart_irq_status_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .evt_frame_err  (evt_frame_err),
  .evt_rx_timeout (evt_rx_timeout),
  .evt_cts_change (evt_cts_change),
  .evt_ser_idle   (evt_ser_idle),
  .eot_mode       (eot_mode),
  .clr_we         (clr_we),
  .clr_data       (clr_data),
  .raw_status     (raw_status),
  .irq            (irq)
);

// File: tb/uart_irq_status_bench.sv
`timescale 1ns/1ps
module uart_irq_status_bench;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             evt_frame_err, evt_rx_timeout, evt_cts_change, evt_ser_idle;
  logic [LVL_W-1:0] rx_level, tx_level;
  logic [2:0]       rx_trig_sel, tx_trig_sel;
  logic             fifo_en, eot_mode, rx_byte_read, tx_byte_write;
  logic             clr_we, mask_we;
  logic [7:0]       clr_data, mask_data;
  logic [7:0]       raw_status;
  logic             irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_irq_status #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_uart_irq_status (
    .clk, .rst_n, .evt_frame_err, .evt_rx_timeout, .evt_cts_change, .evt_ser_idle,
    .rx_level, .tx_level, .rx_trig_sel, .tx_trig_sel, .fifo_en, .eot_mode,
    .rx_byte_read, .tx_byte_write, .clr_we, .clr_data, .mask_we, .mask_data,
    .raw_status, .irq
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Advance one edge; inputs change and outputs are read 1 ns after the edge.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    evt_frame_err = 0; evt_rx_timeout = 0; evt_cts_change = 0; evt_ser_idle = 0;
    rx_byte_read = 0; tx_byte_write = 0; clr_we = 0; clr_data = 0;
    mask_we = 0; mask_data = 0;
  endtask

  task automatic w1c(input logic [7:0] pat);
    clr_we = 1; clr_data = pat; step(); clr_we = 0; clr_data = 0;
  endtask

  task automatic t_reset();
    chk("R1 status after reset", raw_status, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_events();
    evt_frame_err = 1; step(); evt_frame_err = 0;
    chk("R3 framing sets bit7", raw_status, 8'h80);
    evt_rx_timeout = 1; step(); evt_rx_timeout = 0;
    chk("R3 time-out sets bit6", raw_status, 8'hC0);
    evt_cts_change = 1; step(); evt_cts_change = 0;
    chk("R2 cts at bit1", raw_status, 8'hC2);
    step(); step();
    chk("R3 flags hold", raw_status, 8'hC2);
  endtask

  task automatic t_w1c();
    w1c(8'h00);
    chk("R4 zero write no effect", raw_status, 8'hC2);
    w1c(8'h40);
    chk("R4 clear bit6 only", raw_status, 8'h82);
    w1c(8'hFF);
    chk("R4 clear all", raw_status, 8'h00);
    chk("R2 reserved bits zero", raw_status & 8'h0D, 8'h00);
  endtask

  task automatic t_set_wins();
    evt_frame_err = 1; clr_we = 1; clr_data = 8'h80; step();
    evt_frame_err = 0; clr_we = 0; clr_data = 0;
    chk("R5 set beats clear", raw_status, 8'h80);
    w1c(8'h80);
    chk("R5 cleared afterwards", raw_status, 8'h00);
  endtask

  task automatic t_rx_fifo();
    fifo_en = 1; rx_trig_sel = 3'd2;
    rx_level = 7; step();
    chk("R6 below threshold 8", raw_status, 8'h00);
    rx_level = 8; step();
    chk("R6 crossing to 8 sets", raw_status, 8'h10);
    rx_level = 9; clr_we = 1; clr_data = 8'h10; step(); clr_we = 0; clr_data = 0;
    chk("R4 rx cleared by write", raw_status, 8'h00);
    rx_level = 10; step(); step();
    chk("R6 no reset while above", raw_status, 8'h00);
    rx_level = 7; step();
    rx_level = 8; step();
    chk("R6 re-cross sets", raw_status, 8'h10);
    rx_level = 7; step();
    chk("R7 drop below clears", raw_status, 8'h00);
    rx_level = 0; step();
    rx_trig_sel = 3'd0; step();
    rx_level = 1; step();
    chk("R6 code0 level1 no set", raw_status, 8'h00);
    rx_level = 2; step();
    chk("R6 code0 threshold 2", raw_status, 8'h10);
    rx_level = 0; step();
    rx_trig_sel = 3'd4; step();
    rx_level = 13; step();
    chk("R6 code4 level13 no set", raw_status, 8'h00);
    rx_level = 14; step();
    chk("R6 code4 threshold 14", raw_status, 8'h10);
    rx_level = 0; step();
    rx_trig_sel = 3'd7; step();
    rx_level = 13; step();
    rx_level = 14; step();
    chk("R6 code7 saturates to 14", raw_status, 8'h10);
    rx_level = 0; step();
    rx_trig_sel = 3'd3; step();
    rx_level = 11; step();
    rx_level = 12; step();
    chk("R6 code3 threshold 12", raw_status, 8'h10);
    rx_level = 0; step();
    chk("R7 back to empty clears", raw_status, 8'h00);
  endtask

  task automatic t_rx_nofifo();
    fifo_en = 0; step();
    rx_level = 1; step();
    chk("R8 byte arrival sets", raw_status, 8'h10);
    rx_level = 0; step();
    chk("R8 level drop keeps flag", raw_status, 8'h10);
    rx_byte_read = 1; step(); rx_byte_read = 0;
    chk("R8 byte read clears", raw_status, 8'h00);
    fifo_en = 1; step();
  endtask

  task automatic t_tx_fifo();
    fifo_en = 1; eot_mode = 0; tx_trig_sel = 3'd1;
    tx_level = 10; step();
    tx_level = 5; step();
    chk("R9 above threshold 4", raw_status, 8'h00);
    tx_level = 4; step();
    chk("R9 drain to 4 sets", raw_status, 8'h20);
    tx_level = 3; step();
    chk("R9 stays set", raw_status, 8'h20);
    tx_level = 6; step();
    chk("R9 refill clears", raw_status, 8'h00);
    tx_level = 0; step();
    chk("R9 drain again sets", raw_status, 8'h20);
    w1c(8'h20);
    chk("R9 cleared for next test", raw_status, 8'h00);
  endtask

  task automatic t_tx_nofifo();
    fifo_en = 0; step();
    tx_level = 1; step();
    tx_level = 0; step();
    chk("R10 buffer empties sets", raw_status, 8'h20);
    tx_byte_write = 1; step(); tx_byte_write = 0;
    chk("R10 byte write clears", raw_status, 8'h00);
    fifo_en = 1; step();
  endtask

  task automatic t_eot();
    eot_mode = 1; tx_trig_sel = 3'd1;
    tx_level = 5; step();
    tx_level = 4; step();
    chk("R11 crossing ignored", raw_status, 8'h00);
    evt_ser_idle = 1; step(); evt_ser_idle = 0;
    chk("R11 serializer idle sets", raw_status, 8'h20);
    w1c(8'h20);
    tx_level = 0; step();
    eot_mode = 0; step();
  endtask

  task automatic t_mask();
    evt_frame_err = 1; step(); evt_frame_err = 0;
    chk("R12 mask zero blocks irq", {7'd0, irq}, 8'h00);
    mask_we = 1; mask_data = 8'h80; step(); mask_we = 0;
    chk("R12 mask bit7 passes irq", {7'd0, irq}, 8'h01);
    mask_we = 1; mask_data = 8'h40; step(); mask_we = 0;
    chk("R12 other bit masked", {7'd0, irq}, 8'h00);
    evt_rx_timeout = 1; step(); evt_rx_timeout = 0;
    chk("R12 unmasked source irq", {7'd0, irq}, 8'h01);
    w1c(8'hC0);
    chk("R12 irq drops on clear", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rx_level = 0; tx_level = 0; rx_trig_sel = 3'd2; tx_trig_sel = 3'd1;
    fifo_en = 1; eot_mode = 0;
    rst_n = 0;
    #12;
    @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_events();
    t_w1c();
    t_set_wins();
    t_rx_fifo();
    t_rx_nofifo();
    t_tx_fifo();
    t_tx_nofifo();
    t_eot();
    t_mask();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule